// File: doc/BRIEF.md
# Error Record Transfer Engine

This engine moves one error record of variable length between a host-visible exchange buffer and one fixed-size storage slot. A write copies the record from the buffer into a slot, a read copies a stored record back into the buffer at a chosen word offset, and a clear drops a record from the directory. The record length and the record identifier are taken from fixed positions in the record header. Each operation ends with a one-byte status code. The engine checks the offset, the length and the identifier before it moves any data.

The slot directory is outside the block. The engine presents a search key and receives the hit flag and slot index, the first free slot, the first stored identifier and the record count. It reports slot updates and count changes back to the directory. Both memories are one 64-bit word wide, with a one-cycle read latency. The copy moves one word per cycle.

Top module: `erte_top`

## Requirements
- R1: After reset, busy_o, done_o and status_o are 0. While idle, no memory write and no directory update is issued.
- R2: start_i is taken only while idle. busy_o stays high from the accepted start until the cycle in which done_o pulses for one cycle with status_o. A start_i raised while busy has no effect.
- R3: With rec_off_i counted in 8-byte words, a write or read with rec_off_i*8 > BUF_BYTES-128 ends with status 0x03. rec_off_i*8 equal to BUF_BYTES-128 is accepted.
- R4: The record length is the 32-bit little-endian field at byte 20, which is bits 63:32 of header word 2. A length below 128, or above BUF_BYTES - rec_off_i*8, ends with status 0x03. A write takes the length from the buffer and a read takes it from the slot.
- R5: The identifier is the 64-bit field at byte 96, which is header word 12. A write or a clear whose identifier is all zeros or all ones ends with status 0x03.
- R6: A write of an identifier not in the directory goes to the free slot that the directory reports. It raises cnt_inc_o together with the slot update and ends with 0x00. If no slot is free, it ends with 0x01 and writes nothing.
- R7: A write of an identifier already in the directory reuses that slot and does not raise cnt_inc_o.
- R8: A write stores every word of the slot. Byte positions below the length carry the record bytes, and every byte position from the length up to BUF_BYTES is 0xFF.
- R9: A read ends with 0x04 when the record count is 0. An all-zeros identifier is first replaced by the first stored one, reported through sel_upd_o and sel_id_o. An all-ones identifier ends with 0x03.
- R10: A read of an identifier that the directory does not hold ends with 0x05. It also reports the first stored identifier on sel_id_o with sel_upd_o.
- R11: A successful read writes exactly the length in bytes into the buffer from word rec_off_i onward, using byte enables. All other buffer bytes are untouched, and the status is 0x00.
- R12: A clear of a stored identifier updates its slot to identifier 0, raises cnt_dec_o and writes no memory, then ends with 0x00. A clear of an absent identifier ends with 0x05.
- R13: op_i encodes a write as 0, a read as 1 and a clear as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin an operation |
| op_i | input | 2 | operation: 0 write, 1 read, 2 clear |
| rec_off_i | input | OFF_W | record offset in the buffer, in 8-byte words |
| sel_id_i | input | 64 | selected identifier for a read or a clear |
| busy_o | output | 1 | operation in progress |
| done_o | output | 1 | one-cycle end pulse |
| status_o | output | 8 | status code of the last operation |
| sel_upd_o | output | 1 | replace the selected identifier |
| sel_id_o | output | 64 | new selected identifier |
| rec_count_i | input | CNT_W | stored record count |
| dir_key_o | output | 64 | directory search key |
| dir_hit_i | input | 1 | key found |
| dir_idx_i | input | SLOT_W | slot index of the key |
| free_ok_i | input | 1 | a free slot exists |
| free_idx_i | input | SLOT_W | first free slot |
| first_ok_i | input | 1 | a stored record exists |
| first_id_i | input | 64 | first stored identifier |
| dir_upd_o | output | 1 | write a directory entry |
| dir_upd_idx_o | output | SLOT_W | slot of the entry |
| dir_upd_id_o | output | 64 | identifier to store, 0 frees the slot |
| cnt_inc_o | output | 1 | increment the record count |
| cnt_dec_o | output | 1 | decrement the record count |
| xb_re_o | output | 1 | buffer read |
| xb_we_o | output | 1 | buffer write |
| xb_addr_o | output | NW_W | buffer word address |
| xb_be_o | output | 8 | buffer byte enables |
| xb_wdata_o | output | 64 | buffer write data |
| xb_rdata_i | input | 64 | buffer read data, one cycle after xb_re_o |
| sl_re_o | output | 1 | storage read |
| sl_we_o | output | 1 | storage write |
| sl_addr_o | output | SLOT_W+NW_W | storage address, slot then word |
| sl_wdata_o | output | 64 | storage write data |
| sl_rdata_i | input | 64 | storage read data, one cycle after sl_re_o |

## Verification
Counting from the edge that takes start_i, the timing is fixed by where each operation stops. A clear, an empty read and a write with a bad offset end after 1 edge. Read identifier, offset and lookup failures end after 2 edges. Length, identifier and space failures end after 4 edges. Every completed copy ends after BUF_WORDS+5 edges. The driver places each expected status in the scoreboard together with its due cycle. The monitor compares both when done_o is seen, and it flags any done_o that no stimulus predicted. Slot images, buffer contents, the directory and the count are compared only after done_o.

// File: rtl/erte_pkg.sv
package erte_pkg;
  localparam int ID_W     = 64;
  localparam int MIN_REC  = 128;
  localparam int LEN_WORD = 2;   // length field: byte 20 -> word 2, upper half
  localparam int ID_WORD  = 12;  // identifier field: byte 96 -> word 12

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;

  localparam logic [7:0] ST_OK      = 8'h00;
  localparam logic [7:0] ST_NOSPACE = 8'h01;
  localparam logic [7:0] ST_FAIL    = 8'h03;
  localparam logic [7:0] ST_EMPTY   = 8'h04;
  localparam logic [7:0] ST_MISSING = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_RCHK, S_HLEN, S_HID, S_SLEN, S_EVAL, S_COPY
  } st_e;
endpackage

// File: rtl/erte_hdr_chk.sv
module erte_hdr_chk import erte_pkg::*; #(
  parameter int BUF_BYTES = 256,
  parameter int OFF_W     = 16
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [31:0]      len_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             off_bad_o,
  output logic             len_bad_o,
  output logic             id_bad_o
);
  localparam logic [31:0] OFF_MAX = 32'(BUF_BYTES - MIN_REC);

  logic [31:0] off_b, room;
  assign off_b = 32'(off_i) << 3;
  assign room  = 32'(BUF_BYTES) - off_b;   // only meaningful when offset is good

  assign off_bad_o = off_b > OFF_MAX;
  assign len_bad_o = (len_i < 32'(MIN_REC)) || (len_i > room);
  assign id_bad_o  = (id_i == '0) || (id_i == '1);
endmodule

// File: rtl/erte_lane.sv
module erte_lane #(
  parameter int NW_W = 5
) (
  input  logic [31:0]     len_i,
  input  logic [NW_W-1:0] word_i,
  input  logic [63:0]     src_i,
  output logic [7:0]      mask_o,
  output logic [63:0]     fill_o
);
  logic [31:0] base, rem;
  assign base = 32'(word_i) << 3;
  assign rem  = len_i - base;

  always_comb begin
    if (len_i <= base)      mask_o = 8'h00;
    else if (rem >= 32'd8)  mask_o = 8'hFF;
    else                    mask_o = ~(8'hFF << rem[2:0]);
  end

  for (genvar b = 0; b < 8; b++) begin : g_byte
    assign fill_o[8*b +: 8] = mask_o[b] ? src_i[8*b +: 8] : 8'hFF;
  end
endmodule

// File: rtl/erte_top.sv
module erte_top import erte_pkg::*; #(
  parameter int BUF_BYTES = 256,
  parameter int SLOTS     = 8,
  parameter int OFF_W     = 16,
  localparam int NW       = BUF_BYTES / 8,
  localparam int NW_W     = $clog2(NW),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             op_i,
  input  logic [OFF_W-1:0]       rec_off_i,
  input  logic [63:0]            sel_id_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [7:0]             status_o,
  output logic                   sel_upd_o,
  output logic [63:0]            sel_id_o,
  input  logic [CNT_W-1:0]       rec_count_i,
  output logic [63:0]            dir_key_o,
  input  logic                   dir_hit_i,
  input  logic [SLOT_W-1:0]      dir_idx_i,
  input  logic                   free_ok_i,
  input  logic [SLOT_W-1:0]      free_idx_i,
  input  logic                   first_ok_i,
  input  logic [63:0]            first_id_i,
  output logic                   dir_upd_o,
  output logic [SLOT_W-1:0]      dir_upd_idx_o,
  output logic [63:0]            dir_upd_id_o,
  output logic                   cnt_inc_o,
  output logic                   cnt_dec_o,
  output logic                   xb_re_o,
  output logic                   xb_we_o,
  output logic [NW_W-1:0]        xb_addr_o,
  output logic [7:0]             xb_be_o,
  output logic [63:0]            xb_wdata_o,
  input  logic [63:0]            xb_rdata_i,
  output logic                   sl_re_o,
  output logic                   sl_we_o,
  output logic [SLOT_W+NW_W-1:0] sl_addr_o,
  output logic [63:0]            sl_wdata_o,
  input  logic [63:0]            sl_rdata_i
);
  st_e               st_q, st_d;
  logic [1:0]        op_q, op_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [63:0]       id_q, id_d;
  logic [31:0]       len_q, len_d;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic              new_q, new_d;
  logic [NW_W:0]     cnt_q, cnt_d;
  logic [7:0]        status_q;
  logic              done_q;

  logic        finish;
  logic [7:0]  fin_code;
  logic [31:0] xa_sum;
  logic        off_bad, len_bad, id_bad;
  logic [NW_W-1:0] wr_idx;
  logic [7:0]  lane_mask;
  logic [63:0] lane_fill;
  logic        rd_need;

  erte_hdr_chk #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_chk (
    .off_i(off_q), .len_i(len_q), .id_i(id_q),
    .off_bad_o(off_bad), .len_bad_o(len_bad), .id_bad_o(id_bad)
  );

  assign wr_idx = cnt_q[NW_W-1:0] - 1'b1;

  erte_lane #(.NW_W(NW_W)) u_lane (
    .len_i(len_q), .word_i(wr_idx), .src_i(xb_rdata_i),
    .mask_o(lane_mask), .fill_o(lane_fill)
  );

  assign rd_need   = (cnt_q < (NW_W+1)'(NW)) && ((32'(cnt_q) << 3) < len_q);
  assign xb_addr_o = xa_sum[NW_W-1:0];
  assign dir_key_o = id_q;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign status_o  = status_q;

  always_comb begin
    st_d = st_q; op_d = op_q; off_d = off_q; id_d = id_q; len_d = len_q;
    idx_d = idx_q; new_d = new_q; cnt_d = cnt_q;
    finish = 1'b0; fin_code = ST_OK;
    xa_sum = 32'(off_q);
    xb_re_o = 1'b0; xb_we_o = 1'b0; xb_be_o = 8'h00; xb_wdata_o = sl_rdata_i;
    sl_re_o = 1'b0; sl_we_o = 1'b0; sl_addr_o = {idx_q, cnt_q[NW_W-1:0]};
    sl_wdata_o = lane_fill;
    sel_upd_o = 1'b0; sel_id_o = first_ok_i ? first_id_i : '1;
    dir_upd_o = 1'b0; dir_upd_idx_o = idx_q; dir_upd_id_o = id_q;
    cnt_inc_o = 1'b0; cnt_dec_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_PRE; op_d = op_i; off_d = rec_off_i; id_d = sel_id_i;
      end
      S_PRE: begin
        if (op_q == OP_WRITE) begin
          if (off_bad) begin finish = 1'b1; fin_code = ST_FAIL; end
          else begin
            xb_re_o = 1'b1; xa_sum = 32'(off_q) + 32'(LEN_WORD); st_d = S_HLEN;
          end
        end else if (op_q == OP_READ) begin
          if (rec_count_i == '0) begin finish = 1'b1; fin_code = ST_EMPTY; end
          else begin
            if (id_q == '0) begin id_d = sel_id_o; sel_upd_o = 1'b1; end
            st_d = S_RCHK;
          end
        end else begin
          if (id_bad)          begin finish = 1'b1; fin_code = ST_FAIL; end
          else if (!dir_hit_i) begin finish = 1'b1; fin_code = ST_MISSING; end
          else begin
            dir_upd_o = 1'b1; dir_upd_idx_o = dir_idx_i; dir_upd_id_o = '0;
            cnt_dec_o = 1'b1; finish = 1'b1;
          end
        end
      end
      S_RCHK: begin
        if (id_q == '1 || off_bad) begin finish = 1'b1; fin_code = ST_FAIL; end
        else if (!dir_hit_i) begin
          sel_upd_o = 1'b1; finish = 1'b1; fin_code = ST_MISSING;
        end else begin
          idx_d = dir_idx_i; sl_re_o = 1'b1;
          sl_addr_o = {dir_idx_i, NW_W'(LEN_WORD)}; st_d = S_SLEN;
        end
      end
      S_HLEN: begin
        len_d = xb_rdata_i[63:32];
        xb_re_o = 1'b1; xa_sum = 32'(off_q) + 32'(ID_WORD); st_d = S_HID;
      end
      S_HID:  begin id_d = xb_rdata_i; st_d = S_EVAL; end
      S_SLEN: begin len_d = sl_rdata_i[63:32]; st_d = S_EVAL; end
      S_EVAL: begin
        cnt_d = '0;
        if (len_bad) begin finish = 1'b1; fin_code = ST_FAIL; end
        else if (op_q == OP_READ) st_d = S_COPY;
        else if (id_bad) begin finish = 1'b1; fin_code = ST_FAIL; end
        else if (dir_hit_i) begin idx_d = dir_idx_i;  new_d = 1'b0; st_d = S_COPY; end
        else if (free_ok_i) begin idx_d = free_idx_i; new_d = 1'b1; st_d = S_COPY; end
        else begin finish = 1'b1; fin_code = ST_NOSPACE; end
      end
      S_COPY: begin
        cnt_d = cnt_q + 1'b1;
        if (op_q == OP_WRITE) begin
          xb_re_o = rd_need; xa_sum = 32'(off_q) + 32'(cnt_q);
          if (cnt_q != '0) begin sl_we_o = 1'b1; sl_addr_o = {idx_q, wr_idx}; end
        end else begin
          sl_re_o = rd_need;
          if (cnt_q != '0 && lane_mask != 8'h00) begin
            xb_we_o = 1'b1; xb_be_o = lane_mask; xa_sum = 32'(off_q) + 32'(wr_idx);
          end
        end
        if (cnt_q == (NW_W+1)'(NW)) begin
          finish = 1'b1;
          if (op_q == OP_WRITE) begin dir_upd_o = 1'b1; cnt_inc_o = new_q; end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (finish) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_WRITE; off_q <= '0; id_q <= '0; len_q <= '0;
      idx_q <= '0; new_q <= 1'b0; cnt_q <= '0; status_q <= ST_OK; done_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; off_q <= off_d; id_q <= id_d; len_q <= len_d;
      idx_q <= idx_d; new_q <= new_d; cnt_q <= cnt_d;
      done_q <= finish;
      if (finish) status_q <= fin_code;
    end
  end
endmodule

// File: rtl/erte_sva.sv
module erte_sva #(
  parameter int SLOT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [7:0]        status_o,
  input logic              sel_upd_o,
  input logic              dir_upd_o,
  input logic [SLOT_W-1:0] dir_upd_idx_o,
  input logic [63:0]       dir_upd_id_o,
  input logic              cnt_inc_o,
  input logic              cnt_dec_o,
  input logic              xb_we_o,
  input logic              sl_we_o
);
  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!xb_we_o && !sl_we_o && !dir_upd_o && !sel_upd_o));
  assert_done_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_ends_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_wr_id_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_upd_o && !cnt_dec_o) |-> (dir_upd_id_o != '0 && dir_upd_id_o != '1));
  assert_upd_then_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_upd_o |=> (done_o && status_o == 8'h00));
  assert_cnt_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnt_inc_o && cnt_dec_o));
  assert_one_mem_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xb_we_o && sl_we_o));
  assert_code_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == 8'h00 || status_o == 8'h01 || status_o == 8'h03 ||
                status_o == 8'h04 || status_o == 8'h05));
  assert_clear_frees_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_dec_o |-> (dir_upd_o && dir_upd_id_o == '0 && !xb_we_o && !sl_we_o));
endmodule

bind erte_top erte_sva #(.SLOT_W(SLOT_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .status_o(status_o), .sel_upd_o(sel_upd_o), .dir_upd_o(dir_upd_o),
  .dir_upd_idx_o(dir_upd_idx_o), .dir_upd_id_o(dir_upd_id_o),
  .cnt_inc_o(cnt_inc_o), .cnt_dec_o(cnt_dec_o),
  .xb_we_o(xb_we_o), .sl_we_o(sl_we_o)
);

// File: tb/erte_top_tb_top.sv
module erte_top_tb_top;
  localparam int BUF_BYTES = 256;
  localparam int SLOTS     = 4;
  localparam int OFF_W     = 16;
  localparam int NW        = BUF_BYTES / 8;
  localparam int NW_W      = $clog2(NW);
  localparam int SW        = $clog2(SLOTS);
  localparam int CW        = $clog2(SLOTS + 1);
  localparam int LAT_COPY  = NW + 5;

  localparam logic [63:0] ID_A = 64'h1000_0000_0000_00A1;
  localparam logic [63:0] ID_B = 64'h2000_0000_0000_00B2;
  localparam logic [63:0] ID_C = 64'h3000_0000_0000_00C3;
  localparam logic [63:0] ID_D = 64'h4000_0000_0000_00D4;
  localparam logic [63:0] ID_E = 64'h5000_0000_0000_00E5;
  localparam logic [63:0] ID_X = 64'h6000_0000_0000_00F6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start = 1'b0;
  logic [1:0]        op = 2'd0;
  logic [OFF_W-1:0]  off = '0;
  logic [63:0]       sel = '0;
  logic              busy, done, sel_upd, dir_upd, cnt_inc, cnt_dec;
  logic [7:0]        status, xb_be;
  logic [63:0]       sel_id, dir_key, dir_upd_id, xb_wdata, sl_wdata;
  logic [SW-1:0]     dir_upd_idx;
  logic              xb_re, xb_we, sl_re, sl_we;
  logic [NW_W-1:0]   xb_addr;
  logic [SW+NW_W-1:0] sl_addr;
  logic [63:0]       xb_rd = '0, sl_rd = '0;

  logic [63:0] xb_mem [NW];
  logic [63:0] sl_mem [SLOTS*NW];
  logic [63:0] dir_id [SLOTS];
  int          tb_cnt = 0;
  logic [63:0] tb_sel = '0;
  logic        h_we = 1'b0;
  logic [NW_W-1:0] h_addr = '0;
  logic [63:0] h_data = '0;

  logic dir_hit, free_ok, first_ok;
  logic [SW-1:0] dir_idx, free_idx;
  logic [63:0] first_id;

  always_comb begin
    dir_hit = 1'b0; dir_idx = '0; free_ok = 1'b0; free_idx = '0;
    first_ok = 1'b0; first_id = '1;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (dir_id[i] == dir_key && dir_key != '0) begin dir_hit = 1'b1; dir_idx = SW'(i); end
      if (dir_id[i] == '0) begin free_ok = 1'b1; free_idx = SW'(i); end
      if (dir_id[i] != '0) begin first_ok = 1'b1; first_id = dir_id[i]; end
    end
  end

  erte_top #(.BUF_BYTES(BUF_BYTES), .SLOTS(SLOTS), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .rec_off_i(off),
    .sel_id_i(sel), .busy_o(busy), .done_o(done), .status_o(status),
    .sel_upd_o(sel_upd), .sel_id_o(sel_id), .rec_count_i(CW'(tb_cnt)),
    .dir_key_o(dir_key), .dir_hit_i(dir_hit), .dir_idx_i(dir_idx),
    .free_ok_i(free_ok), .free_idx_i(free_idx), .first_ok_i(first_ok),
    .first_id_i(first_id), .dir_upd_o(dir_upd), .dir_upd_idx_o(dir_upd_idx),
    .dir_upd_id_o(dir_upd_id), .cnt_inc_o(cnt_inc), .cnt_dec_o(cnt_dec),
    .xb_re_o(xb_re), .xb_we_o(xb_we), .xb_addr_o(xb_addr), .xb_be_o(xb_be),
    .xb_wdata_o(xb_wdata), .xb_rdata_i(xb_rd), .sl_re_o(sl_re), .sl_we_o(sl_we),
    .sl_addr_o(sl_addr), .sl_wdata_o(sl_wdata), .sl_rdata_i(sl_rd)
  );

  // memory, directory and selected-identifier models
  initial begin
    for (int i = 0; i < NW; i++) xb_mem[i] = '0;
    for (int i = 0; i < SLOTS*NW; i++) sl_mem[i] = '0;
    for (int i = 0; i < SLOTS; i++) dir_id[i] = '0;
  end

  always @(posedge clk) begin
    if (xb_re) xb_rd <= xb_mem[xb_addr];
    if (h_we) xb_mem[h_addr] <= h_data;
    else if (xb_we)
      for (int b = 0; b < 8; b++) if (xb_be[b]) xb_mem[xb_addr][8*b +: 8] <= xb_wdata[8*b +: 8];
    if (sl_re) sl_rd <= sl_mem[sl_addr];
    if (sl_we) sl_mem[sl_addr] <= sl_wdata;
    if (dir_upd) dir_id[dir_upd_idx] <= dir_upd_id;
    if (cnt_inc) tb_cnt <= tb_cnt + 1;
    if (cnt_dec) tb_cnt <= tb_cnt - 1;
    if (sel_upd) tb_sel <= sel_id;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [7:0] st; int due; string req; } exp_t;
  exp_t sbq[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) chk(1'b0, "R2 unpredicted done", 64'(status), 64'hFFFF);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(status == e.st, e.req, 64'(status), 64'(e.st));
        chk(cyc == e.due, {e.req, " due cycle"}, 64'(cyc), 64'(e.due));
        chk(!busy, "R2 busy low at done", 64'(busy), 64'd0);
      end
    end
  end

  task automatic launch(input logic [1:0] o, input int of, input logic [63:0] id,
                        input logic [7:0] st, input int lat, input string req);
    exp_t e;
    @(negedge clk);
    op = o; off = OFF_W'(of); sel = id; start = 1'b1;
    e.st = st; e.due = cyc + 1 + lat; e.req = req;
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
  endtask

  task automatic wait_idle();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] o, input int of, input logic [63:0] id,
                     input logic [7:0] st, input int lat, input string req);
    launch(o, of, id, st, lat, req);
    wait_idle();
  endtask

  logic [63:0] rec [NW];
  logic [63:0] exp_slot [SLOTS][NW];

  task automatic host_wr(input int a, input logic [63:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = NW_W'(a); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic load_rec(input int of, input int len, input logic [63:0] id, input int seed);
    for (int j = 0; j < NW; j++) begin
      rec[j] = {8'hA5, 8'(seed), 8'(j), 8'h3C, 8'(seed * 3), 8'(j + 7), 8'h96, 8'(j ^ seed)};
      if (j == 2)  rec[j][63:32] = 32'(len);
      if (j == 12) rec[j] = id;
      if (of + j < NW) host_wr(of + j, rec[j]);
    end
  endtask

  task automatic set_exp(input int s, input int len);
    for (int j = 0; j < NW; j++)
      for (int b = 0; b < 8; b++)
        exp_slot[s][j][8*b +: 8] = (8*j + b < len) ? rec[j][8*b +: 8] : 8'hFF;
  endtask

  task automatic chk_slot(input int s, input string req);
    int miss;
    miss = -1;
    for (int j = NW - 1; j >= 0; j--) if (sl_mem[s*NW + j] !== exp_slot[s][j]) miss = j;
    if (miss < 0) chk(1'b1, req, 64'd0, 64'd0);
    else chk(1'b0, req, sl_mem[s*NW + miss], exp_slot[s][miss]);
  endtask

  task automatic fill_xb();
    for (int j = 0; j < NW; j++) host_wr(j, 64'h5555_5555_5555_5555);
  endtask

  task automatic chk_xb(input int s, input int of, input int len, input string req);
    int miss;
    logic [63:0] ex, got, bad_ex;
    miss = -1; got = '0; bad_ex = '0;
    for (int k = 0; k < NW; k++) begin
      ex = 64'h5555_5555_5555_5555;
      for (int b = 0; b < 8; b++)
        if (k >= of && 8*(k - of) + b < len) ex[8*b +: 8] = exp_slot[s][k - of][8*b +: 8];
      if (xb_mem[k] !== ex && miss < 0) begin miss = k; got = xb_mem[k]; bad_ex = ex; end
    end
    chk(miss < 0, req, got, bad_ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {62'd0, busy, done}, 64'd0);
    chk(status == 8'h00, "R1 reset status", 64'(status), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: op 0 write, 1 read, 2 clear
    load_rec(0, 256, ID_A, 1); set_exp(0, 256);
    run(2'd0, 0, '0, 8'h00, LAT_COPY, "R6 new write A");
    chk_slot(0, "R6 slot0 image A");
    chk(dir_id[0] == ID_A && tb_cnt == 1, "R6 dir/count after A", dir_id[0], ID_A);

    load_rec(3, 128, ID_B, 2); set_exp(1, 128);
    run(2'd0, 3, '0, 8'h00, LAT_COPY, "R8 write B len 128");
    chk_slot(1, "R8 slot1 0xFF tail");

    // overwrite A, with a start pulse during busy that must be ignored
    load_rec(0, 203, ID_A, 3); set_exp(0, 203);
    launch(2'd0, 0, '0, 8'h00, LAT_COPY, "R7 overwrite A");
    repeat (5) @(negedge clk);
    op = 2'd2; sel = ID_A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk_slot(0, "R8 partial word tail");
    chk(tb_cnt == 2, "R7 count kept on overwrite", 64'(tb_cnt), 64'd2);
    chk(dir_id[0] == ID_A, "R2 start while busy ignored", dir_id[0], ID_A);

    run(2'd0, 17, '0, 8'h03, 1, "R3 write offset too far");
    load_rec(0, 127, ID_X, 4);
    run(2'd0, 0, '0, 8'h03, 4, "R4 length below 128");
    load_rec(4, 225, ID_X, 5);
    run(2'd0, 4, '0, 8'h03, 4, "R4 length past buffer");
    load_rec(0, 128, '0, 6);
    run(2'd0, 0, '0, 8'h03, 4, "R5 write id zeros");
    load_rec(0, 128, '1, 7);
    run(2'd0, 0, '0, 8'h03, 4, "R5 write id ones");
    chk(tb_cnt == 2, "R5 no count change", 64'(tb_cnt), 64'd2);

    load_rec(16, 128, ID_C, 8); set_exp(2, 128);
    run(2'd0, 16, '0, 8'h00, LAT_COPY, "R3 offset at limit");
    chk_slot(2, "R3 slot2 image C");
    load_rec(0, 136, ID_D, 9); set_exp(3, 136);
    run(2'd0, 0, '0, 8'h00, LAT_COPY, "R6 write D");
    load_rec(0, 160, ID_E, 10);
    run(2'd0, 0, '0, 8'h01, 4, "R6 no free slot");
    chk(tb_cnt == 4, "R6 count when full", 64'(tb_cnt), 64'd4);
    chk_slot(3, "R6 slot3 untouched by full write");

    fill_xb();
    run(2'd1, 2, ID_B, 8'h00, LAT_COPY, "R11 read B");
    chk_xb(1, 2, 128, "R11 buffer after read B");
    run(2'd1, 16, ID_A, 8'h03, 4, "R4 read length past buffer");
    fill_xb();
    run(2'd1, 1, ID_A, 8'h00, LAT_COPY, "R11 read A partial word");
    chk_xb(0, 1, 203, "R11 byte enables on A");

    tb_sel = '0;
    run(2'd1, 0, '0, 8'h00, LAT_COPY, "R9 read id zeros");
    chk(tb_sel == ID_A, "R9 zeros replaced by first", tb_sel, ID_A);
    run(2'd1, 0, '1, 8'h03, 2, "R9 read id ones");
    tb_sel = '0;
    run(2'd1, 0, ID_X, 8'h05, 2, "R10 read missing");
    chk(tb_sel == ID_A, "R10 selection reset", tb_sel, ID_A);
    run(2'd1, 17, ID_A, 8'h03, 2, "R3 read offset too far");

    run(2'd2, 0, ID_B, 8'h00, 1, "R12 clear B");
    chk(dir_id[1] == '0 && tb_cnt == 3, "R12 entry freed", dir_id[1], 64'd0);
    chk_slot(1, "R12 data kept");
    run(2'd2, 0, ID_B, 8'h05, 1, "R12 clear absent");
    run(2'd2, 0, '0, 8'h03, 1, "R5 clear id zeros");
    run(2'd2, 0, ID_A, 8'h00, 1, "R12 clear A");
    run(2'd2, 0, ID_C, 8'h00, 1, "R12 clear C");
    run(2'd2, 0, ID_D, 8'h00, 1, "R12 clear D");
    chk(tb_cnt == 0, "R12 count zero", 64'(tb_cnt), 64'd0);
    run(2'd1, 0, ID_A, 8'h04, 1, "R9 read empty store");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule